// File: doc/BRIEF.md
# Privilege-Checked Address Zone Decoder

This block sits between the processor and the memory system and screens each access before anything downstream acts on it. For every request it forms the decode address: a word access has its two lowest bits cleared and a byte access passes through unchanged. It then decides at once whether the access is allowed. User mode may not touch the protected low region below `PRIV_LIMIT`, which is 0x2000000 by default. Privileged modes are never refused.

The block names the target zone by looking up a 5-bit field of the decode address in a 32-entry table. Reads and writes each have their own table, so one address region can resolve differently for each direction. Software or boot logic loads both tables through a configuration write port. Reset fills every entry of both tables with a default zone code.

One zone code marks the memory controller. An allowed write into that zone, with a fixed selector pattern in the address, is a control write. Such a write takes its parameter from an address line, and the block keeps it as an OS-mode flag. The write data is never examined.

Top module: `priv_zone_decoder`

## Requirements
- R1: For a word access (`req_word`=1) `addr_o` equals `req_addr` with bits [1:0] forced to 0. For a byte access (`req_word`=0) `addr_o` equals `req_addr` unchanged. Both hold in the same cycle as the request.
- R2: A valid request in user mode (`req_mode`=2'b00) whose decode address is below 0x2000000 raises `abort_o` in the same cycle, for reads and writes alike. With `req_valid`=0, `abort_o` is 0.
- R3: A valid user-mode request whose decode address is at or above 0x2000000 does not raise `abort_o`.
- R4: A request in any privileged mode (`req_mode` 2'b01, 2'b10 or 2'b11) never raises `abort_o`, whatever its address.
- R5: `zone_o` is the entry at index `addr_o`[25:21]. The entry comes from the read table when `req_write`=0 and from the write table when `req_write`=1. It is combinational from the request.
- R6: A configuration write (`cfg_we`=1) stores `cfg_zone` at index `cfg_idx` of the read table when `cfg_sel`=0, or of the write table when `cfg_sel`=1. It is visible from the next cycle, and the other table is left untouched.
- R7: After reset every entry of both tables holds zone code 0 and `os_mode_o` is 0.
- R8: A valid, non-aborted write whose write-table zone is the controller code 3'd1 and whose `addr_o`[19:17] is 3'b111 is a control write. From the next cycle `os_mode_o` equals `addr_o`[12], and it may move either to 1 or to 0.
- R9: `os_mode_o` is unchanged by reads, by writes to any zone other than the controller code, and by controller-zone writes whose bits [19:17] are not all ones.
- R10: An aborted access leaves `os_mode_o` unchanged, even when its address matches the control-write pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 26 | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for a word access, 0 for a byte access |
| req_mode | input | 2 | Processor mode: 00 user, other values privileged |
| cfg_we | input | 1 | Zone table configuration write strobe |
| cfg_sel | input | 1 | Selects the table: 0 read, 1 write |
| cfg_idx | input | 5 | Table entry index |
| cfg_zone | input | 3 | Zone code to store |
| abort_o | output | 1 | Access refused |
| zone_o | output | 3 | Selected zone code |
| addr_o | output | 26 | Decode address after alignment |
| os_mode_o | output | 1 | OS-mode flag captured by the last control write |

## Verification
The bench probes the privilege boundary on both sides: 0x1FFFFFF and 0x1FFFFFC are refused for user mode, and 0x2000000 is allowed. A design that compared against the wrong limit, or checked the address before alignment, would get one side wrong. It loads distinct patterns into the two tables and rewrites a single read entry. A design that shared a table between directions, or let a configuration write spill into the other table, would report the wrong zone. It drives writes that almost match the control pattern, a read and a user-mode write to a low controller zone, and a user-mode control write to a high controller zone. A design that latched on a partial match, ignored the direction, or let an aborted access through would move the OS-mode flag when it should hold, or hold it when it should move.

// File: rtl/pzd_pkg.sv
package pzd_pkg;

    typedef enum logic [1:0] {
        MODE_USER = 2'b00,
        MODE_FIQ  = 2'b01,
        MODE_IRQ  = 2'b10,
        MODE_SVC  = 2'b11
    } cpu_mode_e;

    function automatic logic is_unprivileged(input cpu_mode_e m);
        return m == MODE_USER;
    endfunction

endpackage

// File: rtl/pzd_access_check.sv
module pzd_access_check
    import pzd_pkg::*;
#(
    parameter int          ADDR_W     = 26,
    parameter int unsigned PRIV_LIMIT = 32'h0200_0000
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              word_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_al_o,
    output logic              abort_o
);

    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(PRIV_LIMIT);

    cpu_mode_e mode;

    always_comb begin
        mode = cpu_mode_e'(mode_i);
        if (word_i) begin
            addr_al_o = {addr_i[ADDR_W-1:2], 2'b00};
        end else begin
            addr_al_o = addr_i;
        end
        abort_o = valid_i && is_unprivileged(mode) && (addr_al_o < LIMIT_A);
    end

endmodule

// File: rtl/pzd_zone_table.sv
module pzd_zone_table #(
    parameter int IDX_W        = 5,
    parameter int ZONE_W       = 3,
    parameter int DEFAULT_ZONE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ZONE_W-1:0] wr_zone_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ZONE_W-1:0] rd_zone_o
);

    localparam int                DEPTH = 1 << IDX_W;
    localparam logic [ZONE_W-1:0] DEF_Z = ZONE_W'(DEFAULT_ZONE);

    typedef struct packed {
        logic [DEPTH-1:0][ZONE_W-1:0] ent;
    } tab_state_t;

    tab_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.ent[wr_idx_i] = wr_zone_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ent <= {DEPTH{DEF_Z}};
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_zone_o = state_q.ent[rd_idx_i];

endmodule

// File: rtl/pzd_ctrl_capture.sv
module pzd_ctrl_capture #(
    parameter int ZONE_W     = 3,
    parameter int CTRL_ZONE  = 1,
    parameter int SEL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              write_i,
    input  logic              abort_i,
    input  logic [ZONE_W-1:0] zone_i,
    input  logic [SEL_W-1:0]  sel_bits_i,
    input  logic              os_bit_i,
    output logic              os_mode_o
);

    localparam logic [ZONE_W-1:0] CTRL_Z = ZONE_W'(CTRL_ZONE);

    typedef struct packed {
        logic os_mode;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic       hit;

    always_comb begin
        hit = valid_i && write_i && !abort_i && (zone_i == CTRL_Z) && (&sel_bits_i);
        state_d = state_q;
        if (hit) begin
            state_d.os_mode = os_bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign os_mode_o = state_q.os_mode;

endmodule

// File: rtl/priv_zone_decoder.sv
module priv_zone_decoder #(
    parameter int          ADDR_W       = 26,
    parameter int          ZONE_W       = 3,
    parameter int          IDX_W        = 5,
    parameter int          IDX_LO       = 21,
    parameter int unsigned PRIV_LIMIT   = 32'h0200_0000,
    parameter int          CTRL_ZONE    = 1,
    parameter int          DEFAULT_ZONE = 0,
    parameter int          SEL_LO       = 17,
    parameter int          SEL_W        = 3,
    parameter int          OS_BIT       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [1:0]        req_mode,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ZONE_W-1:0] cfg_zone,
    output logic              abort_o,
    output logic [ZONE_W-1:0] zone_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              os_mode_o
);

    localparam int N_TAB = 2;

    logic [ADDR_W-1:0] addr_al;
    logic              abort;
    logic [ZONE_W-1:0] tab_zone [N_TAB];
    logic [IDX_W-1:0]  zone_idx;

    pzd_access_check #(
        .ADDR_W     (ADDR_W),
        .PRIV_LIMIT (PRIV_LIMIT)
    ) i_check (
        .valid_i   (req_valid),
        .addr_i    (req_addr),
        .word_i    (req_word),
        .mode_i    (req_mode),
        .addr_al_o (addr_al),
        .abort_o   (abort)
    );

    assign zone_idx = addr_al[IDX_LO +: IDX_W];

    for (genvar t = 0; t < N_TAB; t++) begin : g_tab
        pzd_zone_table #(
            .IDX_W        (IDX_W),
            .ZONE_W       (ZONE_W),
            .DEFAULT_ZONE (DEFAULT_ZONE)
        ) i_tab (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (cfg_we && (cfg_sel == 1'(t))),
            .wr_idx_i  (cfg_idx),
            .wr_zone_i (cfg_zone),
            .rd_idx_i  (zone_idx),
            .rd_zone_o (tab_zone[t])
        );
    end

    assign zone_o  = tab_zone[req_write];
    assign abort_o = abort;
    assign addr_o  = addr_al;

    pzd_ctrl_capture #(
        .ZONE_W    (ZONE_W),
        .CTRL_ZONE (CTRL_ZONE),
        .SEL_W     (SEL_W)
    ) i_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (req_valid),
        .write_i    (req_write),
        .abort_i    (abort),
        .zone_i     (tab_zone[1]),
        .sel_bits_i (addr_al[SEL_LO +: SEL_W]),
        .os_bit_i   (addr_al[OS_BIT]),
        .os_mode_o  (os_mode_o)
    );

endmodule

// File: rtl/priv_zone_decoder_chk.sv
module priv_zone_decoder_chk #(
    parameter int          ADDR_W     = 26,
    parameter int unsigned PRIV_LIMIT = 32'h0200_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              req_word,
    input logic [1:0]        req_mode,
    input logic              abort_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              os_mode_o
);

    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(PRIV_LIMIT);

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_word |-> (addr_o[1:0] == 2'b00 && addr_o[ADDR_W-1:2] == req_addr[ADDR_W-1:2])); // R1

    AST_BYTE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_word |-> (addr_o == req_addr)); // R1

    AST_USER_LOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00 && req_addr < LIMIT_A) |-> abort_o); // R2

    AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !abort_o); // R2

    AST_USER_HIGH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode == 2'b00 && req_addr >= LIMIT_A) |-> !abort_o); // R3

    AST_PRIV_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode != 2'b00) |-> !abort_o); // R4

    AST_OS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(os_mode_o)); // R9

    AST_OS_HOLD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> $stable(os_mode_o)); // R10

endmodule

bind priv_zone_decoder priv_zone_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .PRIV_LIMIT (PRIV_LIMIT)
) i_priv_zone_decoder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_word  (req_word),
    .req_mode  (req_mode),
    .abort_o   (abort_o),
    .addr_o    (addr_o),
    .os_mode_o (os_mode_o)
);

// File: tb/test_priv_zone_decoder.sv
module test_priv_zone_decoder;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [1:0]  req_mode = 2'b11;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [2:0]  cfg_zone = '0;
    logic        abort_o;
    logic [2:0]  zone_o;
    logic [25:0] addr_o;
    logic        os_mode_o;

    always #(CLK_P/2) clk = ~clk;

    priv_zone_decoder i_priv_zone_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_word  (req_word),
        .req_mode  (req_mode),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_idx   (cfg_idx),
        .cfg_zone  (cfg_zone),
        .abort_o   (abort_o),
        .zone_o    (zone_o),
        .addr_o    (addr_o),
        .os_mode_o (os_mode_o)
    );

    typedef struct {
        logic        abort;
        logic [2:0]  zone;
        logic [25:0] addr;
        logic        os;
        string       tag;
    } item_t;

    item_t       sb_q [$];
    logic [2:0]  rd_tab [32];
    logic [2:0]  wr_tab [32];
    logic        model_os = 1'b0;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done = 1'b0;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg(input logic sel, input int idx, input logic [2:0] z);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_idx   = 5'(idx);
        cfg_zone  = z;
        if (sel) wr_tab[idx] = z;
        else     rd_tab[idx] = z;
    endtask

    task automatic access(input logic [25:0] a, input logic wr, input logic wd,
                          input logic [1:0] md, input logic vld, input string tag);
        logic [25:0] al;
        logic        ab;
        logic [2:0]  z;
        item_t       it;
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = vld;
        req_addr  = a;
        req_write = wr;
        req_word  = wd;
        req_mode  = md;
        al = wd ? {a[25:2], 2'b00} : a;
        ab = vld && (md == 2'b00) && (al < 26'h200_0000);
        z  = wr ? wr_tab[al[25:21]] : rd_tab[al[25:21]];
        it.abort = ab;
        it.zone  = z;
        it.addr  = al;
        it.os    = model_os;
        it.tag   = tag;
        sb_q.push_back(it);
        if (vld && wr && !ab && z == 3'd1 && al[19:17] == 3'b111) model_os = al[12];
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(abort_o == it.abort, it.tag, "abort", 32'(abort_o), 32'(it.abort));
                check(zone_o == it.zone, it.tag, "zone", 32'(zone_o), 32'(it.zone));
                check(addr_o == it.addr, it.tag, "addr", 32'(addr_o), 32'(it.addr));
                check(os_mode_o == it.os, it.tag, "os_mode", 32'(os_mode_o), 32'(it.os));
            end
        end
    end

    initial begin : watchdog
        #(CLK_P * 50000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 32; i++) begin
            rd_tab[i] = 3'd0;
            wr_tab[i] = 3'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: every entry of both tables defaults to 0, os flag 0
        for (int i = 0; i < 32; i++) begin
            access(26'(i << 21), 1'b0, 1'b1, 2'b11, 1'b1, "R7");
            access(26'(i << 21), 1'b1, 1'b1, 2'b11, 1'b1, "R7");
        end

        // R6: load distinct patterns into both tables
        for (int i = 0; i < 32; i++) begin
            cfg(1'b0, i, 3'(i % 8));
            cfg(1'b1, i, 3'((i + 3) % 8));
        end
        // R5: each index in each direction returns its own table entry
        for (int i = 0; i < 32; i++) begin
            access(26'((i << 21) | 32'h100), 1'b0, 1'b1, 2'b11, 1'b1, "R5");
            access(26'((i << 21) | 32'h100), 1'b1, 1'b1, 2'b11, 1'b1, "R5");
        end
        // R6: rewrite one read entry; write table entry at same index keeps its value
        cfg(1'b0, 9, 3'd7);
        access(26'h120_0000, 1'b0, 1'b1, 2'b11, 1'b1, "R6");
        access(26'h120_0000, 1'b1, 1'b1, 2'b11, 1'b1, "R6");

        // R1: alignment of word and byte addresses
        access(26'h240_0003, 1'b0, 1'b1, 2'b11, 1'b1, "R1");
        access(26'h240_0003, 1'b0, 1'b0, 2'b11, 1'b1, "R1");
        access(26'h3FF_FFFE, 1'b1, 1'b0, 2'b00, 1'b1, "R1");

        // R2: user mode below the limit aborts, reads and writes
        access(26'h1FF_FFFF, 1'b0, 1'b0, 2'b00, 1'b1, "R2");
        access(26'h1FF_FFFF, 1'b1, 1'b1, 2'b00, 1'b1, "R2");
        access(26'h000_0000, 1'b1, 1'b0, 2'b00, 1'b1, "R2");
        access(26'h000_0000, 1'b0, 1'b0, 2'b00, 1'b0, "R2");
        // R3: user mode at and above the limit is allowed
        access(26'h200_0000, 1'b0, 1'b1, 2'b00, 1'b1, "R3");
        access(26'h3FF_FFFF, 1'b1, 1'b0, 2'b00, 1'b1, "R3");
        // R4: privileged modes are never refused
        access(26'h000_0000, 1'b0, 1'b0, 2'b01, 1'b1, "R4");
        access(26'h100_0000, 1'b1, 1'b1, 2'b10, 1'b1, "R4");
        access(26'h1FF_FFFF, 1'b1, 1'b0, 2'b11, 1'b1, "R4");

        // R8: control write through low controller zone (index 6) sets the flag
        access(26'h0CE_1000, 1'b1, 1'b1, 2'b11, 1'b1, "R8");
        // R9: partial pattern, read, and non-controller zone leave it
        access(26'h0CC_0000, 1'b1, 1'b1, 2'b11, 1'b1, "R9");
        access(26'h0CE_0000, 1'b0, 1'b1, 2'b11, 1'b1, "R9");
        access(26'h0AE_0000, 1'b1, 1'b1, 2'b11, 1'b1, "R9");
        // R10: aborted user write matching the pattern leaves it
        access(26'h0CE_0000, 1'b1, 1'b1, 2'b00, 1'b1, "R10");
        access(26'h000_0000, 1'b0, 1'b0, 2'b11, 1'b0, "R10");
        // R8: privileged control write clears the flag
        access(26'h0CE_0000, 1'b1, 1'b0, 2'b11, 1'b1, "R8");
        // R8: user control write in a high controller zone (index 22) sets it
        access(26'h2CE_1003, 1'b1, 1'b0, 2'b00, 1'b1, "R8");
        access(26'h000_0000, 1'b0, 1'b0, 2'b11, 1'b0, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule